// File: doc/BRIEF.md
# Clock Health Event Logger

This block keeps a short circular history of rare clock-health events so that firmware can inspect it after the fact. It watches six trigger sources. Three are single-cycle pulses: brownout, configuration write failure and resume from sleep. Three are detected changes: a toggle of the lock indication, a toggle of the fail indication, and a change of the active profile number. In any cycle where at least one trigger fires, one record goes into a DEPTH-entry ring. The record holds a free-running timestamp, a 3-bit event class, the active profile number, the index of the last readback mismatch and the hash of the golden configuration.

When the ring is full, each new event replaces the oldest record and sets a sticky overflow flag. When several triggers fire in the same cycle, the lowest class code is stored and each of the others adds one to a saturating dropped-event counter.

Software reads records from oldest to newest through a request/acknowledge port that has its own read cursor. Two resets are used:
- The power-on clear (`por_n`) wipes everything.
- The soft reset (`soft_rst_n`) keeps the ring, the timestamp, the overflow flag and the dropped count. It only rewinds the read cursor, so the surviving history can be read again after a restart.

The ring is controlled by a three-state machine:
- BLANK: nothing recorded.
- FILLING: 1 to DEPTH-1 records held.
- WRAPPING: full, and every new event overwrites.

Transitions:
- Power-on clear goes to BLANK.
- BLANK to FILLING on the first event.
- FILLING to WRAPPING on the event that stores record number DEPTH.
- WRAPPING stays in WRAPPING until power-on clear.

Top module: `clk_health_log`

## Requirements
- R1: The event class codes are: 0 brownout pulse, 1 configuration write failure pulse, 2 fail indication toggled, 3 lock indication toggled, 4 resume pulse, 5 profile number changed. A change means the input differs from its value at the previous clock edge. Codes 6 and 7 are never stored.
- R2: A stored record carries the profile number, mismatch index and configuration hash present at the inputs in the cycle the event is taken. For a profile change, that is the new profile number.
- R3: The timestamp is 0 in the first cycle after power-on clear is released and rises by one per clock, saturating at all ones. A record carries the timestamp of its event cycle. Soft reset does not clear the timestamp, so records read out in order have non-decreasing timestamps.
- R4: When k>1 triggers fire in one cycle, the lowest code is recorded and the dropped-event counter grows by k-1, saturating at all ones.
- R5: With DEPTH records held, a new event discards the oldest record. The overflow flag then reads 1 and stays 1 until power-on clear.
- R6: A read request taken at a clock edge gives rd_ack_o=1 in the following cycle. rd_valid_o=1 in that cycle means the returned record is the oldest one not yet read. rd_valid_o=0 means no unread record remained.
- R7: While soft reset is low, no trigger is recorded and read requests are ignored (rd_ack_o=0). Ring contents, overflow flag, dropped count and timestamp are kept. The read cursor rewinds to the oldest record. A lock or profile change during soft reset does not produce an event at release.
- R8: While power-on clear is low, the ring, overflow flag, dropped count, timestamp and read port are cleared. Afterwards rd_ack_o=0, overflow_o=0 and drop_cnt_o=0.
- R9: If an event overwrites while some records have already been read, the read cursor keeps pointing at the same not-yet-read record. If the unread record at the cursor is the one discarded, the cursor moves to the new oldest record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on clear, synchronous, active low |
| soft_rst_n | input | 1 | Soft reset, synchronous, active low |
| lock_i | input | 1 | Lock indication level |
| fail_i | input | 1 | Fail indication level |
| cfg_wr_fail_i | input | 1 | Configuration write failure pulse |
| brownout_i | input | 1 | Brownout pulse |
| resume_i | input | 1 | Resume-from-sleep pulse |
| profile_i | input | PW | Active profile number |
| mism_idx_i | input | MW | Index of last readback mismatch |
| cfg_hash_i | input | HW | Hash of the golden configuration |
| rd_req_i | input | 1 | Read request, one record per cycle high |
| rd_ack_o | output | 1 | Read response strobe |
| rd_valid_o | output | 1 | Response carries a record |
| rd_ts_o | output | TSW | Record timestamp |
| rd_class_o | output | 3 | Record event class |
| rd_profile_o | output | PW | Record profile number |
| rd_mism_o | output | MW | Record mismatch index |
| rd_hash_o | output | HW | Record configuration hash |
| overflow_o | output | 1 | Sticky overflow flag |
| drop_cnt_o | output | DCW | Saturating dropped-event counter |

## Verification
The properties assume that `por_n` is low from time zero, because the edge-history registers hold unknown values before the first clock. They also assume that the timestamp never saturates, since a saturated counter would still satisfy the ordering check only by staying equal. The stimulus holds power-on clear low for the opening cycles and runs far fewer cycles than the timestamp range. It applies soft reset and power-on clear only as pulses of a few cycles. Random pulses are kept sparse enough that several-trigger cycles, overwrites and empty reads all occur, while staying well below the dropped counter's saturation.

// File: rtl/chl_pkg.sv
package chl_pkg;

    localparam int NUM_TRIG = 6;
    localparam int CLS_W    = 3;

    // Lower code wins when several triggers coincide
    typedef enum logic [CLS_W-1:0] {
        EV_BROWNOUT = 3'd0,
        EV_WRFAIL   = 3'd1,
        EV_FAILCHG  = 3'd2,
        EV_LOCKCHG  = 3'd3,
        EV_RESUME   = 3'd4,
        EV_PROFSW   = 3'd5
    } ev_class_e;

    typedef enum logic [1:0] {
        ST_BLANK    = 2'd0,
        ST_FILLING  = 2'd1,
        ST_WRAPPING = 2'd2
    } ring_state_e;

endpackage

// File: rtl/chl_trigger.sv
module chl_trigger #(
    parameter int PW  = 3,
    parameter int DCW = 8
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                soft_rst_n,
    input  logic                lock_i,
    input  logic                fail_i,
    input  logic                wrf_i,
    input  logic                bo_i,
    input  logic                res_i,
    input  logic [PW-1:0]       prof_i,
    output logic                ev_vld_o,
    output chl_pkg::ev_class_e  ev_cls_o,
    output logic [DCW-1:0]      drop_o
);
    import chl_pkg::*;

    localparam int NW = $clog2(NUM_TRIG + 1);

    logic                lock_q;
    logic                fail_q;
    logic [PW-1:0]       prof_q;
    logic                armed;
    logic [NUM_TRIG-1:0] hit;
    logic [NW-1:0]       nhit;
    logic [DCW-1:0]      drop_q;
    logic [DCW:0]        dsum;

    // Edge history follows the inputs in every cycle, reset or not,
    // so leaving a reset never shows a stale difference.
    always_ff @(posedge clk) begin
        lock_q <= lock_i;
        fail_q <= fail_i;
        prof_q <= prof_i;
    end

    assign armed = por_n && soft_rst_n;

    always_comb begin
        hit[EV_BROWNOUT] = bo_i;
        hit[EV_WRFAIL]   = wrf_i;
        hit[EV_FAILCHG]  = (fail_i != fail_q);
        hit[EV_LOCKCHG]  = (lock_i != lock_q);
        hit[EV_RESUME]   = res_i;
        hit[EV_PROFSW]   = (prof_i != prof_q);
        if (!armed) begin
            hit = '0;
        end
    end

    // Priority pick: scan downwards so the lowest set code is assigned last
    always_comb begin
        ev_cls_o = EV_BROWNOUT;
        for (int i = NUM_TRIG - 1; i >= 0; i--) begin
            if (hit[i]) begin
                ev_cls_o = ev_class_e'(3'(i));
            end
        end
    end

    assign ev_vld_o = |hit;
    assign nhit     = NW'($countones(hit));
    assign dsum     = {1'b0, drop_q} + (DCW+1)'(nhit) - (DCW+1)'(1);

    always_ff @(posedge clk) begin
        if (!por_n) begin
            drop_q <= '0;
        end else if (nhit > NW'(1)) begin
            drop_q <= dsum[DCW] ? '1 : dsum[DCW-1:0];
        end
    end

    assign drop_o = drop_q;

endmodule

// File: rtl/chl_ring.sv
module chl_ring #(
    parameter int DEPTH = 8,
    parameter int RW    = 52
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          soft_rst_n,
    input  logic          ev_vld_i,
    input  logic [RW-1:0] rec_i,
    input  logic          rd_req_i,
    output logic          rd_ack_o,
    output logic          rd_valid_o,
    output logic [RW-1:0] rd_rec_o,
    output logic          overflow_o
);
    import chl_pkg::*;

    // DEPTH must be a power of two, at least 2
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    ring_state_e   state_q, state_d;
    logic [RW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr_q;
    logic [CW-1:0] count_q;
    logic [CW-1:0] rd_ofs_q;
    logic [CW-1:0] ofs_step;
    logic [CW-1:0] ofs_nx;
    logic [AW-1:0] rd_idx;
    logic          ovf_q;
    logic          cnt_en;
    logic          overwrite;
    logic          rd_hit;
    logic          ack_q, vld_q;
    logic [RW-1:0] rec_q;

    // State register
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state_q <= ST_BLANK;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and control outputs
    always_comb begin
        state_d   = state_q;
        cnt_en    = 1'b0;
        overwrite = 1'b0;
        unique case (state_q)
            ST_BLANK: begin
                cnt_en = ev_vld_i;
                if (ev_vld_i) begin
                    state_d = ST_FILLING;
                end
            end
            ST_FILLING: begin
                cnt_en = ev_vld_i;
                if (ev_vld_i && count_q == CW'(DEPTH - 1)) begin
                    state_d = ST_WRAPPING;
                end
            end
            ST_WRAPPING: begin
                overwrite = ev_vld_i;
            end
            default: begin
                state_d = ST_BLANK;
            end
        endcase
    end

    // Read addressing relative to the oldest record
    assign rd_idx   = AW'(wr_ptr_q - count_q[AW-1:0] + rd_ofs_q[AW-1:0]);
    assign rd_hit   = rd_req_i && (rd_ofs_q < count_q);
    assign ofs_step = rd_ofs_q + CW'(rd_hit);
    assign ofs_nx   = (overwrite && ofs_step != '0) ? ofs_step - CW'(1) : ofs_step;

    always_ff @(posedge clk) begin
        if (por_n && ev_vld_i) begin
            mem[wr_ptr_q] <= rec_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            wr_ptr_q <= '0;
            count_q  <= '0;
            ovf_q    <= 1'b0;
            rd_ofs_q <= '0;
            ack_q    <= 1'b0;
            vld_q    <= 1'b0;
            rec_q    <= '0;
        end else begin
            if (ev_vld_i) begin
                wr_ptr_q <= wr_ptr_q + AW'(1);
            end
            if (cnt_en) begin
                count_q <= count_q + CW'(1);
            end
            if (overwrite) begin
                ovf_q <= 1'b1;
            end
            if (!soft_rst_n) begin
                rd_ofs_q <= '0;
                ack_q    <= 1'b0;
                vld_q    <= 1'b0;
            end else begin
                rd_ofs_q <= ofs_nx;
                ack_q    <= rd_req_i;
                vld_q    <= rd_hit;
                if (rd_req_i) begin
                    rec_q <= mem[rd_idx];
                end
            end
        end
    end

    assign rd_ack_o   = ack_q;
    assign rd_valid_o = vld_q;
    assign rd_rec_o   = rec_q;
    assign overflow_o = ovf_q;

endmodule

// File: rtl/clk_health_log.sv
module clk_health_log #(
    parameter int DEPTH = 8,
    parameter int TSW   = 32,
    parameter int PW    = 3,
    parameter int MW    = 6,
    parameter int HW    = 8,
    parameter int DCW   = 8
) (
    input  logic           clk,
    input  logic           por_n,
    input  logic           soft_rst_n,
    input  logic           lock_i,
    input  logic           fail_i,
    input  logic           cfg_wr_fail_i,
    input  logic           brownout_i,
    input  logic           resume_i,
    input  logic [PW-1:0]  profile_i,
    input  logic [MW-1:0]  mism_idx_i,
    input  logic [HW-1:0]  cfg_hash_i,
    input  logic           rd_req_i,
    output logic           rd_ack_o,
    output logic           rd_valid_o,
    output logic [TSW-1:0] rd_ts_o,
    output logic [2:0]     rd_class_o,
    output logic [PW-1:0]  rd_profile_o,
    output logic [MW-1:0]  rd_mism_o,
    output logic [HW-1:0]  rd_hash_o,
    output logic           overflow_o,
    output logic [DCW-1:0] drop_cnt_o
);
    import chl_pkg::*;

    localparam int RW     = TSW + CLS_W + PW + MW + HW;
    localparam int HASH_L = 0;
    localparam int MISM_L = HASH_L + HW;
    localparam int PROF_L = MISM_L + MW;
    localparam int CLS_L  = PROF_L + PW;
    localparam int TS_L   = CLS_L + CLS_W;

    logic [TSW-1:0] ts_q;
    logic           ev_vld;
    ev_class_e      ev_cls;
    logic [RW-1:0]  rec;
    logic [RW-1:0]  rd_rec;

    // Timestamp only clears on power-on, saturates instead of wrapping
    always_ff @(posedge clk) begin
        if (!por_n) begin
            ts_q <= '0;
        end else if (ts_q != '1) begin
            ts_q <= ts_q + TSW'(1);
        end
    end

    chl_trigger #(.PW(PW), .DCW(DCW)) u_trig (
        .clk        (clk),
        .por_n      (por_n),
        .soft_rst_n (soft_rst_n),
        .lock_i     (lock_i),
        .fail_i     (fail_i),
        .wrf_i      (cfg_wr_fail_i),
        .bo_i       (brownout_i),
        .res_i      (resume_i),
        .prof_i     (profile_i),
        .ev_vld_o   (ev_vld),
        .ev_cls_o   (ev_cls),
        .drop_o     (drop_cnt_o)
    );

    assign rec = {ts_q, ev_cls, profile_i, mism_idx_i, cfg_hash_i};

    chl_ring #(.DEPTH(DEPTH), .RW(RW)) u_ring (
        .clk        (clk),
        .por_n      (por_n),
        .soft_rst_n (soft_rst_n),
        .ev_vld_i   (ev_vld),
        .rec_i      (rec),
        .rd_req_i   (rd_req_i),
        .rd_ack_o   (rd_ack_o),
        .rd_valid_o (rd_valid_o),
        .rd_rec_o   (rd_rec),
        .overflow_o (overflow_o)
    );

    assign rd_ts_o      = rd_rec[TS_L +: TSW];
    assign rd_class_o   = rd_rec[CLS_L +: CLS_W];
    assign rd_profile_o = rd_rec[PROF_L +: PW];
    assign rd_mism_o    = rd_rec[MISM_L +: MW];
    assign rd_hash_o    = rd_rec[HASH_L +: HW];

endmodule

// File: rtl/chl_chk.sv
module chl_chk #(
    parameter int TSW = 32,
    parameter int DCW = 8
) (
    input logic           clk,
    input logic           por_n,
    input logic           soft_rst_n,
    input logic           rd_req_i,
    input logic           rd_ack_o,
    input logic           rd_valid_o,
    input logic [TSW-1:0] rd_ts_o,
    input logic [2:0]     rd_class_o,
    input logic           overflow_o,
    input logic [DCW-1:0] drop_cnt_o
);
    logic [TSW-1:0] last_ts;

    always_ff @(posedge clk) begin
        if (!por_n || !soft_rst_n) begin
            last_ts <= '0;
        end else if (rd_valid_o) begin
            last_ts <= rd_ts_o;
        end
    end

    // R6
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rd_req_i && soft_rst_n) |=> rd_ack_o);

    // R6
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!por_n)
        rd_ack_o |-> $past(rd_req_i));

    // R6
    valid_in_ack_chk: assert property (@(posedge clk) disable iff (!por_n)
        rd_valid_o |-> rd_ack_o);

    // R5
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        overflow_o |=> overflow_o);

    // R4
    drop_no_decrease_chk: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> (drop_cnt_o >= $past(drop_cnt_o)));

    // R3
    ts_order_chk: assert property (@(posedge clk) disable iff (!por_n)
        rd_valid_o |-> (rd_ts_o >= last_ts));

    // R1
    class_range_chk: assert property (@(posedge clk) disable iff (!por_n)
        rd_valid_o |-> (rd_class_o <= 3'd5));

    // R7
    soft_blocks_ack_chk: assert property (@(posedge clk) disable iff (!por_n)
        !soft_rst_n |=> !rd_ack_o);

endmodule

bind clk_health_log chl_chk #(.TSW(TSW), .DCW(DCW)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .soft_rst_n (soft_rst_n),
    .rd_req_i   (rd_req_i),
    .rd_ack_o   (rd_ack_o),
    .rd_valid_o (rd_valid_o),
    .rd_ts_o    (rd_ts_o),
    .rd_class_o (rd_class_o),
    .overflow_o (overflow_o),
    .drop_cnt_o (drop_cnt_o)
);

// File: tb/sim_clk_health_log.sv
`timescale 1ns/1ps
module sim_clk_health_log;

    localparam int DEPTH = 8;

    typedef struct {
        logic [31:0] ts;
        logic [2:0]  cls;
        logic [2:0]  prof;
        logic [5:0]  mism;
        logic [7:0]  hash;
    } rec_t;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       soft_rst_n = 1'b1;
    logic       lock_i = 1'b0, fail_i = 1'b0, wrf_i = 1'b0, bo_i = 1'b0, res_i = 1'b0;
    logic [2:0] prof_i = 3'd0;
    logic [5:0] mism_i = 6'd0;
    logic [7:0] hash_i = 8'h00;
    logic       rd_req_i = 1'b0;
    logic       rd_ack_o, rd_valid_o, overflow_o;
    logic [31:0] rd_ts_o;
    logic [2:0] rd_class_o, rd_profile_o;
    logic [5:0] rd_mism_o;
    logic [7:0] rd_hash_o, drop_cnt_o;

    always #2 clk = ~clk;

    clk_health_log #(.DEPTH(DEPTH), .TSW(32), .PW(3), .MW(6), .HW(8), .DCW(8)) u0 (
        .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n),
        .lock_i(lock_i), .fail_i(fail_i), .cfg_wr_fail_i(wrf_i),
        .brownout_i(bo_i), .resume_i(res_i), .profile_i(prof_i),
        .mism_idx_i(mism_i), .cfg_hash_i(hash_i), .rd_req_i(rd_req_i),
        .rd_ack_o(rd_ack_o), .rd_valid_o(rd_valid_o), .rd_ts_o(rd_ts_o),
        .rd_class_o(rd_class_o), .rd_profile_o(rd_profile_o),
        .rd_mism_o(rd_mism_o), .rd_hash_o(rd_hash_o),
        .overflow_o(overflow_o), .drop_cnt_o(drop_cnt_o)
    );

    int   n_chk = 0, n_bad = 0;
    bit   done = 0;
    rec_t m_log[$];
    rec_t m_exp;
    int   m_ofs = 0;
    logic [31:0] m_ts = 0;
    logic [7:0]  m_drop = 0;
    bit   m_ovf = 0, m_ack = 0, m_vld = 0;
    logic p_lock = 0, p_fail = 0;
    logic [2:0] p_prof = 0;
    logic [31:0] last_rd_ts = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model, applied once per clock edge with the pre-edge inputs
    task automatic model_edge();
        bit [5:0] hits;
        int k, ofs1;
        rec_t r;
        hits = {prof_i != p_prof, res_i, lock_i != p_lock, fail_i != p_fail, wrf_i, bo_i};
        if (!(por_n && soft_rst_n)) hits = '0;
        p_lock = lock_i; p_fail = fail_i; p_prof = prof_i;
        if (!por_n) begin
            m_log.delete(); m_ofs = 0; m_ovf = 0; m_drop = 0;
            m_ack = 0; m_vld = 0; m_ts = 0;
            return;
        end
        k = $countones(hits);
        if (k > 1) m_drop = (int'(m_drop) + k - 1 > 255) ? 8'hff : 8'(int'(m_drop) + k - 1);
        ofs1 = m_ofs;
        if (!soft_rst_n) begin
            m_ack = 0; m_vld = 0; ofs1 = 0;
        end else begin
            m_ack = rd_req_i;
            m_vld = rd_req_i && (m_ofs < m_log.size());
            if (m_vld) begin
                m_exp = m_log[m_ofs];
                ofs1 = m_ofs + 1;
            end
        end
        if (k > 0) begin
            r.ts = m_ts; r.prof = prof_i; r.mism = mism_i; r.hash = hash_i;
            r.cls = 3'd0;
            for (int i = 5; i >= 0; i--) if (hits[i]) r.cls = 3'(i);
            if (m_log.size() == DEPTH) begin
                void'(m_log.pop_front());
                m_ovf = 1;
                if (ofs1 > 0) ofs1--;
            end
            m_log.push_back(r);
        end
        m_ofs = ofs1;
        if (m_ts != 32'hffff_ffff) m_ts++;
    endtask

    task automatic compare();
        chk(rd_ack_o == m_ack, "R6", "rd_ack", 64'(rd_ack_o), 64'(m_ack));
        chk(rd_valid_o == m_vld, "R6", "rd_valid", 64'(rd_valid_o), 64'(m_vld));
        chk(overflow_o == m_ovf, "R5", "overflow", 64'(overflow_o), 64'(m_ovf));
        chk(drop_cnt_o == m_drop, "R4", "drop_cnt", 64'(drop_cnt_o), 64'(m_drop));
        if (rd_valid_o && m_vld) begin
            chk(rd_ts_o == m_exp.ts, "R3", "timestamp", 64'(rd_ts_o), 64'(m_exp.ts));
            chk(rd_ts_o >= last_rd_ts, "R3", "ts order", 64'(rd_ts_o), 64'(last_rd_ts));
            last_rd_ts = rd_ts_o;
            chk(rd_class_o == m_exp.cls, "R1", "class", 64'(rd_class_o), 64'(m_exp.cls));
            chk(rd_profile_o == m_exp.prof, "R2", "profile", 64'(rd_profile_o), 64'(m_exp.prof));
            chk(rd_mism_o == m_exp.mism, "R2", "mismatch", 64'(rd_mism_o), 64'(m_exp.mism));
            chk(rd_hash_o == m_exp.hash, "R2", "hash", 64'(rd_hash_o), 64'(m_exp.hash));
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (!soft_rst_n || !por_n) last_rd_ts = 0;
        compare();
        wrf_i = 0; bo_i = 0; res_i = 0; rd_req_i = 0;
    endtask

    task automatic read_one();
        rd_req_i = 1; step();
    endtask

    initial begin
        rec_t keep;
        void'($urandom(32'h5eed_0042));
        repeat (3) step();
        // R8: power-on clear state
        chk(!rd_ack_o && !overflow_o && drop_cnt_o == 0, "R8", "reset state",
            64'({rd_ack_o, overflow_o, drop_cnt_o}), 64'(0));
        por_n = 1; step();
        // R6: empty read
        read_one();
        chk(rd_ack_o && !rd_valid_o, "R6", "empty read", 64'(rd_valid_o), 64'(0));
        // R4: three triggers together
        bo_i = 1; wrf_i = 1; res_i = 1; mism_i = 6'd17; hash_i = 8'hA5; step();
        chk(drop_cnt_o == 8'd2, "R4", "drop after triple", 64'(drop_cnt_o), 64'(2));
        // R1 / R2: lock toggle, then profile change
        lock_i = 1; step();
        prof_i = 3'd2; mism_i = 6'd33; hash_i = 8'h3C; step();
        fail_i = 1; step();
        read_one(); read_one(); read_one(); read_one();
        chk(rd_valid_o && rd_class_o == 3'd2, "R1", "fail change class", 64'(rd_class_o), 64'(2));
        // R5: overfill
        for (int i = 0; i < 10; i++) begin res_i = 1; mism_i = 6'(i); step(); end
        chk(overflow_o, "R5", "overflow set", 64'(overflow_o), 64'(1));
        // R7: soft reset keeps history, rewinds cursor, ignores triggers
        keep = m_log[0];
        soft_rst_n = 0; lock_i = 0; prof_i = 3'd5; step();
        res_i = 1; rd_req_i = 1; step();
        chk(!rd_ack_o, "R7", "ack during soft reset", 64'(rd_ack_o), 64'(0));
        soft_rst_n = 1; step(); step();
        chk(overflow_o && drop_cnt_o == 8'd2, "R7", "flags kept",
            64'({overflow_o, drop_cnt_o}), 64'({1'b1, 8'd2}));
        read_one();
        chk(rd_valid_o && rd_ts_o == keep.ts, "R7", "oldest after soft reset",
            64'(rd_ts_o), 64'(keep.ts));
        // R9: overwrite while partly read
        read_one();
        for (int i = 0; i < 3; i++) begin bo_i = 1; step(); end
        read_one();
        chk(rd_valid_o && rd_ts_o == m_exp.ts && rd_ts_o > keep.ts, "R9",
            "cursor after overwrite", 64'(rd_ts_o), 64'(m_exp.ts));
        // Random phase
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 99) < 5)  lock_i = ~lock_i;
            if ($urandom_range(0, 99) < 3)  fail_i = ~fail_i;
            if ($urandom_range(0, 99) < 4)  wrf_i = 1;
            if ($urandom_range(0, 99) < 2)  bo_i = 1;
            if ($urandom_range(0, 99) < 3)  res_i = 1;
            if ($urandom_range(0, 99) < 4)  prof_i = 3'($urandom);
            if ($urandom_range(0, 99) < 30) rd_req_i = 1;
            mism_i = 6'($urandom); hash_i = 8'($urandom);
            soft_rst_n = ($urandom_range(0, 199) != 0);
            step();
        end
        soft_rst_n = 1;
        // R8: power-on clear mid-run
        por_n = 0; step(); step(); por_n = 1; step();
        chk(!overflow_o && drop_cnt_o == 0, "R8", "cleared by POR",
            64'({overflow_o, drop_cnt_o}), 64'(0));
        read_one();
        chk(rd_ack_o && !rd_valid_o, "R8", "ring empty after POR", 64'(rd_valid_o), 64'(0));
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule